// File: doc/BRIEF.md
# Serial ADC read controller

This block is the host side of a link to a 12-bit successive-approximation converter that has a read-only serial port with three wires: an active-low select, a data clock driven by the host, and a single data line returned by the converter. The controller divides the system clock down to the data clock. It paces conversions at a sample rate set by parameters and drops select between frames, which lets the converter rest in its low-power state. It shifts in each result and presents it as a sign-extended two's-complement word, together with a one-cycle valid strobe.

After reset the controller waits for the converter's power-on time. It then runs one throwaway frame, which the converter needs to set up its track-and-hold, and only after that starts real sampling. Each frame begins with two acquisition clocks and one null bit, and none of these are captured. The result bits follow, most significant first. A short-cycle mode ends the frame early after a chosen number of result bits. This saves converter power at the cost of resolution. The missing low bits are returned as zero and the sample is flagged as reduced.

Top module: `adc_rd_ctrl`

## Requirements
- R1: While reset is high and for POR_CYC = (CLK_HZ/1e6)*POR_US cycles after its release, sel_n stays 1, dclk 0, busy 0, smp_valid 0 and smp_data 0.
- R2: At POR_CYC cycles after reset release, one start-up frame runs with 16 rising dclk edges whatever short_en and short_bits are. It never raises smp_valid.
- R3: dclk is 0 whenever sel_n is 1. Within a frame, dclk first rises HALF_DIV cycles after sel_n falls and then toggles every HALF_DIV cycles, where HALF_DIV = ceil(CLK_HZ / (2*DCLK_HZ)).
- R4: A full-resolution frame has exactly 16 rising dclk edges, and sel_n rises in the same cycle as the 16th falling edge.
- R5: sdi is sampled on the cycle in which dclk rises. Rising edges 1 and 2 (acquisition) and edge 3 (null bit) are discarded. Edges 4 to 15 give result bits 11 down to 0. Edge 16 is discarded.
- R6: smp_valid is high for exactly one cycle, the first cycle with sel_n high after a non-start-up frame. smp_data holds the 12-bit result sign-extended to OUT_W bits (bit 11 copied upward) and does not change at any other time.
- R7: When short_en is 1 and short_bits is between 1 and 11, the frame captures short_bits result bits on edges 4 to 3+short_bits. sel_n rises on falling edge 3+short_bits. The uncaptured low bits read as 0 and smp_reduced is 1. Any other setting gives a full frame with smp_reduced 0.
- R8: short_en and short_bits are sampled only in the cycle a frame starts. Changes while a frame is in progress do not affect that frame's length, data or smp_reduced.
- R9: Successive frame starts are FRAME_DIV = CLK_HZ/SAMPLE_HZ cycles apart, but sel_n always stays high for at least MIN_GAP = 2*HALF_DIV*GAP_DCLKS cycles between frames.
- R10: busy is 1 exactly in the cycles where sel_n is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| short_en | input | 1 | Request short-cycle frames |
| short_bits | input | $clog2(ADC_BITS+1) | Result bits to keep in short-cycle mode |
| sdi | input | 1 | Serial data from the converter |
| sel_n | output | 1 | Active-low converter select |
| dclk | output | 1 | Data clock to the converter |
| busy | output | 1 | Frame in progress |
| smp_data | output | OUT_W | Sign-extended sample |
| smp_valid | output | 1 | One-cycle strobe for a new sample |
| smp_reduced | output | 1 | Sample came from a short-cycle frame |

## Verification
The converter model returns a 1 on the two acquisition edges and a 0 on the null edge. A capture window that is off by one edge in either direction therefore corrupts codes such as 7FF, 800, 001 and FFF, which also separate correct sign extension from zero fill. Short frames with 1, 4 and 11 kept bits show both the truncation point and the select timing. Out-of-range settings (12 and 0) must fall back to full frames. During every frame the mode inputs already carry the next frame's settings, which shows that they are latched at the start of the frame. The start-up frame carries a code of its own and a short-cycle request, and both must be ignored.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    // Rising edges before the first result bit: two acquisition, one null.
    localparam int unsigned LEAD_EDGES  = 3;
    // Rising edges of a full-resolution frame.
    localparam int unsigned FRAME_EDGES = 16;
    localparam int unsigned EC_W        = 5;

    typedef logic [EC_W-1:0] edge_cnt_t;

    typedef enum logic [1:0] {
        SEQ_POR   = 2'd0,
        SEQ_IDLE  = 2'd1,
        SEQ_FRAME = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic      dummy;
        logic      reduced;
        edge_cnt_t nbits;
    } frame_cfg_t;

    function automatic int unsigned div_ceil(int unsigned num, int unsigned den);
        return (num + den - 1) / den;
    endfunction

    function automatic logic short_ok(logic en, edge_cnt_t bits, edge_cnt_t full);
        return en && (bits != '0) && (bits < full);
    endfunction

    function automatic edge_cnt_t last_edge(frame_cfg_t c);
        return c.reduced ? edge_cnt_t'(LEAD_EDGES) + c.nbits : edge_cnt_t'(FRAME_EDGES);
    endfunction

endpackage

// File: rtl/adc_rd_clkgen.sv
module adc_rd_clkgen #(
    parameter int unsigned HALF_DIV = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic dclk,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int unsigned HC_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [HC_W-1:0] HALF_LAST = HC_W'(HALF_DIV - 1);

    logic [HC_W-1:0] hcnt;
    logic            tick;

    assign tick     = run && (hcnt == HALF_LAST);
    assign rise_stb = tick && !dclk;
    assign fall_stb = tick && dclk;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            hcnt <= '0;
            dclk <= 1'b0;
        end else if (tick) begin
            hcnt <= '0;
            dclk <= !dclk;
        end else begin
            hcnt <= hcnt + 1'b1;
        end
    end
endmodule

// File: rtl/adc_rd_seq.sv
module adc_rd_seq
    import adc_rd_pkg::*;
#(
    parameter int unsigned ADC_BITS  = 12,
    parameter int unsigned POR_CYC   = 250000,
    parameter int unsigned FRAME_DIV = 500,
    parameter int unsigned MIN_GAP   = 64
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          short_en,
    input  logic [$clog2(ADC_BITS+1)-1:0] short_bits,
    input  logic                          rise_stb,
    input  logic                          fall_stb,
    output logic                          sel_n,
    output logic                          run,
    output logic                          busy,
    output logic                          cap_en,
    output logic                          clr,
    output logic                          done,
    output logic                          reduced,
    output edge_cnt_t                     nbits
);
    localparam int unsigned POR_W  = $clog2(POR_CYC + 1);
    localparam int unsigned PACE_W = $clog2(FRAME_DIV + 1);
    localparam int unsigned GAP_W  = $clog2(MIN_GAP + 1);
    localparam logic [POR_W-1:0]  POR_LAST  = POR_W'(POR_CYC - 1);
    localparam logic [PACE_W-1:0] PACE_LAST = PACE_W'(FRAME_DIV - 1);
    localparam logic [GAP_W-1:0]  GAP_LAST  = GAP_W'(MIN_GAP - 1);
    localparam edge_cnt_t FULL_N = edge_cnt_t'(ADC_BITS);
    localparam edge_cnt_t LEAD_N = edge_cnt_t'(LEAD_EDGES);

    seq_state_e        st;
    logic [POR_W-1:0]  por_cnt;
    logic [PACE_W-1:0] pace_cnt;
    logic [GAP_W-1:0]  gap_cnt;
    edge_cnt_t         edge_cnt;
    edge_cnt_t         req_bits;
    frame_cfg_t        cfg;
    frame_cfg_t        next_cfg;
    logic              start;
    logic              finish;

    assign req_bits = edge_cnt_t'(short_bits);

    always_comb begin
        next_cfg.dummy   = (st == SEQ_POR);
        next_cfg.reduced = !next_cfg.dummy && short_ok(short_en, req_bits, FULL_N);
        next_cfg.nbits   = next_cfg.reduced ? req_bits : FULL_N;
    end

    assign start  = ((st == SEQ_POR) && (por_cnt == POR_LAST)) ||
                    ((st == SEQ_IDLE) && (pace_cnt == PACE_LAST) && (gap_cnt == GAP_LAST));
    assign finish = (st == SEQ_FRAME) && fall_stb && (edge_cnt == last_edge(cfg));

    assign run     = (st == SEQ_FRAME);
    assign busy    = (st == SEQ_FRAME);
    assign clr     = start;
    assign done    = finish && !cfg.dummy;
    assign reduced = cfg.reduced;
    assign nbits   = cfg.nbits;
    assign cap_en  = (st == SEQ_FRAME) && rise_stb && (edge_cnt >= LEAD_N) &&
                     (edge_cnt < LEAD_N + cfg.nbits);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= SEQ_POR;
            por_cnt  <= '0;
            pace_cnt <= '0;
            gap_cnt  <= '0;
            edge_cnt <= '0;
            cfg      <= '0;
            sel_n    <= 1'b1;
        end else begin
            if (pace_cnt != PACE_LAST) pace_cnt <= pace_cnt + 1'b1;
            unique case (st)
                SEQ_POR:  por_cnt <= por_cnt + 1'b1;
                SEQ_IDLE: if (gap_cnt != GAP_LAST) gap_cnt <= gap_cnt + 1'b1;
                SEQ_FRAME: begin
                    if (rise_stb) edge_cnt <= edge_cnt + 1'b1;
                    if (finish) begin
                        st      <= SEQ_IDLE;
                        sel_n   <= 1'b1;
                        gap_cnt <= '0;
                    end
                end
                default: st <= SEQ_POR;
            endcase
            if (start) begin
                st       <= SEQ_FRAME;
                sel_n    <= 1'b0;
                edge_cnt <= '0;
                pace_cnt <= '0;
                cfg      <= next_cfg;
            end
        end
    end
endmodule

// File: rtl/adc_rd_capture.sv
module adc_rd_capture
    import adc_rd_pkg::*;
#(
    parameter int unsigned ADC_BITS = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic                cap_en,
    input  logic                sdi,
    input  edge_cnt_t           nbits,
    output logic [ADC_BITS-1:0] aligned
);
    localparam edge_cnt_t FULL_N = edge_cnt_t'(ADC_BITS);

    logic [ADC_BITS-1:0] acc;
    edge_cnt_t           shamt;

    assign shamt   = FULL_N - nbits;
    assign aligned = acc << shamt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc <= '0;
        end else if (cap_en) begin
            acc <= {acc[ADC_BITS-2:0], sdi};
        end
    end
endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
    import adc_rd_pkg::*;
#(
    parameter int unsigned CLK_HZ    = 100_000_000,
    parameter int unsigned DCLK_HZ   = 3_200_000,
    parameter int unsigned SAMPLE_HZ = 200_000,
    parameter int unsigned POR_US    = 2500,
    parameter int unsigned GAP_DCLKS = 2,
    parameter int unsigned ADC_BITS  = 12,
    parameter int unsigned OUT_W     = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          short_en,
    input  logic [$clog2(ADC_BITS+1)-1:0] short_bits,
    input  logic                          sdi,
    output logic                          sel_n,
    output logic                          dclk,
    output logic                          busy,
    output logic [OUT_W-1:0]              smp_data,
    output logic                          smp_valid,
    output logic                          smp_reduced
);
    localparam int unsigned HALF_DIV  = div_ceil(CLK_HZ, 2 * DCLK_HZ);
    localparam int unsigned FRAME_DIV = CLK_HZ / SAMPLE_HZ;
    localparam int unsigned POR_CYC   = (CLK_HZ / 1_000_000) * POR_US;
    localparam int unsigned MIN_GAP   = 2 * HALF_DIV * GAP_DCLKS;

    logic                run;
    logic                rise_stb;
    logic                fall_stb;
    logic                cap_en;
    logic                clr;
    logic                done;
    logic                reduced;
    edge_cnt_t           nbits;
    logic [ADC_BITS-1:0] aligned;
    logic [OUT_W-1:0]    ext;

    adc_rd_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .dclk     (dclk),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    adc_rd_seq #(
        .ADC_BITS  (ADC_BITS),
        .POR_CYC   (POR_CYC),
        .FRAME_DIV (FRAME_DIV),
        .MIN_GAP   (MIN_GAP)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .short_en   (short_en),
        .short_bits (short_bits),
        .rise_stb   (rise_stb),
        .fall_stb   (fall_stb),
        .sel_n      (sel_n),
        .run        (run),
        .busy       (busy),
        .cap_en     (cap_en),
        .clr        (clr),
        .done       (done),
        .reduced    (reduced),
        .nbits      (nbits)
    );

    adc_rd_capture #(.ADC_BITS(ADC_BITS)) u_capture (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .cap_en  (cap_en),
        .sdi     (sdi),
        .nbits   (nbits),
        .aligned (aligned)
    );

    generate
        if (OUT_W > ADC_BITS) begin : g_sext
            assign ext = {{(OUT_W - ADC_BITS){aligned[ADC_BITS-1]}}, aligned};
        end else begin : g_plain
            assign ext = aligned;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_valid   <= 1'b0;
            smp_data    <= '0;
            smp_reduced <= 1'b0;
        end else begin
            smp_valid <= done;
            if (done) begin
                smp_data    <= ext;
                smp_reduced <= reduced;
            end
        end
    end
endmodule

// File: rtl/adc_rd_ctrl_chk.sv
module adc_rd_ctrl_chk #(
    parameter int unsigned HALF    = 16,
    parameter int unsigned MIN_GAP = 64,
    parameter int unsigned EDGES   = 16,
    parameter int unsigned OUT_W   = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             sel_n,
    input logic             dclk,
    input logic             smp_valid,
    input logic [OUT_W-1:0] smp_data
);
    logic [15:0] hi_cnt;
    logic [15:0] lo_cnt;
    logic [4:0]  rise_cnt;
    logic        dclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt   <= '0;
            lo_cnt   <= '0;
            rise_cnt <= '0;
            dclk_q   <= 1'b0;
        end else begin
            dclk_q <= dclk;
            if (sel_n) begin
                lo_cnt <= '0;
                if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 1'b1;
            end else begin
                hi_cnt <= '0;
                if (lo_cnt != 16'hFFFF) lo_cnt <= lo_cnt + 1'b1;
            end
            if (sel_n) rise_cnt <= '0;
            else if (dclk && !dclk_q && rise_cnt != 5'h1F) rise_cnt <= rise_cnt + 1'b1;
        end
    end

    // R3
    idle_clk_low_chk: assert property (@(posedge clk) disable iff (rst) sel_n |-> !dclk);
    // R3
    setup_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dclk) |-> (lo_cnt >= HALF));
    // R9
    gap_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sel_n) |-> (hi_cnt >= MIN_GAP));
    // R4
    edge_limit_chk: assert property (@(posedge clk) disable iff (rst) rise_cnt <= EDGES);
    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst) smp_valid |=> !smp_valid);
    // R6
    valid_at_end_chk: assert property (@(posedge clk) disable iff (rst) smp_valid |-> $rose(sel_n));
    // R6
    data_hold_chk: assert property (@(posedge clk) disable iff (rst) !smp_valid |-> $stable(smp_data));
endmodule

bind adc_rd_ctrl adc_rd_ctrl_chk #(
    .HALF    (HALF_DIV),
    .MIN_GAP (MIN_GAP),
    .EDGES   (16),
    .OUT_W   (OUT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sel_n     (sel_n),
    .dclk      (dclk),
    .smp_valid (smp_valid),
    .smp_data  (smp_data)
);

// File: tb/adc_rd_ctrl_bench.sv
module adc_rd_ctrl_bench;
    localparam int unsigned CLK_HZ    = 32_000_000;
    localparam int unsigned DCLK_HZ   = 2_000_000;
    localparam int unsigned SAMPLE_HZ = 100_000;
    localparam int unsigned POR_US    = 5;
    localparam int unsigned GAP_DCLKS = 2;
    localparam int H         = (CLK_HZ + 2 * DCLK_HZ - 1) / (2 * DCLK_HZ);
    localparam int FRAME_DIV = CLK_HZ / SAMPLE_HZ;
    localparam int POR_CYC   = (CLK_HZ / 1_000_000) * POR_US;
    localparam int MIN_GAP   = 2 * H * GAP_DCLKS;
    localparam int NFR       = 11;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        short_en = 1'b0;
    logic [3:0]  short_bits = 4'd0;
    logic        sdi = 1'b1;
    logic        sel_n, dclk, busy, smp_valid, smp_reduced;
    logic [15:0] smp_data;

    always #2 clk = ~clk;

    adc_rd_ctrl #(
        .CLK_HZ(CLK_HZ), .DCLK_HZ(DCLK_HZ), .SAMPLE_HZ(SAMPLE_HZ),
        .POR_US(POR_US), .GAP_DCLKS(GAP_DCLKS), .ADC_BITS(12), .OUT_W(16)
    ) u_adc_rd_ctrl (
        .clk(clk), .rst(rst), .short_en(short_en), .short_bits(short_bits),
        .sdi(sdi), .sel_n(sel_n), .dclk(dclk), .busy(busy),
        .smp_data(smp_data), .smp_valid(smp_valid), .smp_reduced(smp_reduced)
    );

    // Frame 0 is the start-up frame.
    int codes   [NFR] = '{'hABC, 'h7FF, 'h800, 'h001, 'hFFF, 'h555, 'hA5A, 'h3C3, 'h9E7, 'h123, 'h800};
    int cfg_en  [NFR] = '{1, 0, 0, 0, 0, 1, 1, 1, 1, 1, 0};
    int cfg_bits[NFR] = '{3, 0, 0, 0, 0, 4, 1, 11, 12, 0, 5};

    int n_chk = 0;
    int n_err = 0;
    int n_valid = 0;
    bit done_flag = 0;

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    // Behavioural reference: 0 = power-on wait, 1 = idle, 2 = frame
    int m_st = 0;
    int e = 0, fc = 0, ss = 0, se = 0, mf = -1, m_len = 0;
    int m_dummy = 0, m_red = 0, m_exp = 0;
    int exp_valid = 0, exp_data = 0, exp_red = 0;

    always @(posedge clk) begin
        if (!rst) begin
            int n;
            e++;
            exp_valid = 0;
            if (m_st == 0) begin
                if (e == POR_CYC) begin
                    m_st = 2; fc = 0; ss = 0; mf++; m_dummy = 1;
                    m_red = 0; m_len = 16;
                end
            end else if (m_st == 1) begin
                ss++; se++;
                if (ss >= FRAME_DIV && se >= MIN_GAP) begin
                    m_st = 2; fc = 0; ss = 0; mf++; m_dummy = 0;
                    m_red = (short_en && short_bits >= 1 && short_bits <= 11) ? 1 : 0;
                    n = m_red ? int'(short_bits) : 12;
                    m_len = m_red ? 3 + n : 16;
                    m_exp = (codes[mf] >> (12 - n)) << (12 - n);
                    if (m_exp & 'h800) m_exp = m_exp | 'hF000;
                end
            end else begin
                ss++; fc++;
                if (fc == 2 * m_len * H) begin
                    m_st = 1; se = 0;
                    if (!m_dummy) begin
                        exp_valid = 1; exp_data = m_exp; exp_red = m_red;
                    end
                end
            end
        end
    end

    // Mode inputs: always show the next frame's settings (R8)
    always @(negedge clk) begin
        if (mf + 1 < NFR) begin
            short_en   = cfg_en[mf + 1][0];
            short_bits = 4'(cfg_bits[mf + 1]);
        end
    end

    // Converter model: output changes after each falling data-clock edge
    int a_idx = -1;
    int a_j = 0;
    always @(negedge sel_n) begin
        a_idx++; a_j = 0; sdi = 1'b1;
    end
    always @(negedge dclk) begin
        if (!sel_n && a_idx >= 0) begin
            a_j++;
            if (a_j <= 1) sdi = 1'b1;
            else if (a_j == 2) sdi = 1'b0;
            else if (a_j <= 14) sdi = codes[a_idx][14 - a_j];
            else sdi = 1'b1;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            string stag;
            int exp_sel, exp_clk;
            exp_sel = (m_st == 2) ? 0 : 1;
            exp_clk = (m_st == 2 && ((fc / H) % 2) == 1) ? 1 : 0;
            if (m_st == 0) stag = "R1 select during power-on wait";
            else if (m_st == 1) stag = "R9 select between frames";
            else if (m_dummy) stag = "R2 start-up frame select";
            else if (m_red) stag = "R7 short frame select";
            else stag = "R4 full frame select";
            chk(sel_n == exp_sel[0], stag, sel_n, exp_sel);
            chk(dclk == exp_clk[0], "R3 data clock", dclk, exp_clk);
            chk(busy == !sel_n, "R10 busy", busy, !sel_n);
            chk(smp_valid == exp_valid[0], (mf <= 0) ? "R2 no start-up sample" : "R6 valid strobe",
                smp_valid, exp_valid);
            if (smp_valid) n_valid++;
            if (exp_valid) begin
                chk(smp_data == exp_data[15:0], exp_red ? "R7 short data" : "R5 capture data",
                    smp_data, exp_data);
                chk(smp_reduced == exp_red[0], "R8 latched mode flag", smp_reduced, exp_red);
            end else begin
                chk(smp_data == exp_data[15:0], "R6 data hold", smp_data, exp_data);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(sel_n == 1'b1, "R1 reset sel_n", sel_n, 1);
        chk(dclk == 1'b0, "R1 reset dclk", dclk, 0);
        chk(busy == 1'b0, "R1 reset busy", busy, 0);
        chk(smp_valid == 1'b0, "R1 reset valid", smp_valid, 0);
        chk(smp_data == 16'h0, "R1 reset data", smp_data, 0);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        wait (mf == NFR - 1 && m_st == 1);
        repeat (40) @(negedge clk);
        chk(n_valid == NFR - 1, "R6 sample count", n_valid, NFR - 1);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", mf, NFR - 1);
        finish_run();
    end
endmodule